// File: doc/BRIEF.md
# Ones-Complement Sequential Multiply/Divide Engine

This block performs signed multiply and divide for an 18-bit ones-complement datapath that keeps a double-length value in an accumulator/IO register pair. A request carries the operation, the accumulator, the IO register and the memory operand. The engine strips the signs, runs a magnitude loop with one add or subtract per clock, and then applies the signs. It returns the new accumulator and IO values and a skip flag that reports a successful divide.

Requests enter on a valid/ready pair. `in_ready` is high only while the engine is idle. A request is taken on a rising edge where both `in_valid` and `in_ready` are high, and all operands are captured on that edge. Results leave on a second valid/ready pair. `out_valid` stays high, with the result held unchanged, until a rising edge where `out_ready` is also high. The engine then returns to idle. No new request is taken while a result is waiting, so back-pressure on the output stalls the input side as well.

Top module: `ones_mdu`

## Requirements
- R1: `in_ready` is 1 only in the idle state. It is 0 from the accepting edge until the result handshake completes, and inputs driven in that interval change nothing.
- R2: Multiply (`in_op` = 0) uses the magnitudes |ac| and |mem|. A negative value, with the sign in the MSB, has magnitude equal to its bitwise complement, so minus zero counts as zero. For a non-negative result, {out_ac,out_io} = 2·|ac|·|mem|. `in_io` has no effect on a multiply.
- R3: When the MSBs of ac and mem differ and the product pair is nonzero, out_ac and out_io are both complemented. A zero product is always returned as all zeros. `out_skip` is 0 after a multiply.
- R4: Divide (`in_op` = 1) takes the dividend D = {ac,io}, complementing both halves when ac is negative. With N = D>>1 and v = |mem|, the unsigned quotient is N/v and the unsigned remainder is N mod v.
- R5: The quotient is returned in out_ac and is complemented when the MSBs of ac and mem differ and the quotient is nonzero. The remainder is returned in out_io and is complemented when the original ac is negative and the remainder is nonzero.
- R6: If the dividend's high-half magnitude is ≥ v (this includes v = 0), the divide returns out_ac = in_ac, out_io = in_io and out_skip = 0. Every other divide returns out_skip = 1.
- R7: Counting the accepting edge as 1, `out_valid` rises after edge W+1 for a multiply, after edge W+2 for a divide, and after edge 1 for a divide that overflows.
- R8: While `out_valid` is 1 and `out_ready` is 0, out_ac, out_io and out_skip hold steady. `out_valid` falls after the handshake edge.
- R9: During and straight after reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Engine idle, request accepted this edge if valid |
| in_op | input | 1 | 0 multiply, 1 divide |
| in_ac | input | W | Accumulator operand (high half of dividend) |
| in_io | input | W | IO operand (low half of dividend) |
| in_mem | input | W | Multiplicand or divisor |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes result this edge |
| out_ac | output | W | New accumulator (product high / quotient) |
| out_io | output | W | New IO (product low / remainder) |
| out_skip | output | 1 | Divide succeeded |

## Verification
The assertions assume the consumer eventually raises `out_ready`, and that the request inputs are sampled only on an edge where `in_ready` is high. The bench keeps to this by completing every handshake before it issues the next request. It also deliberately holds `in_valid` high with altered operands while the engine is busy, and it stalls `out_ready` for a few cycles on a subset of requests. Every operand pair at a 6-bit width is swept for both operations, which covers ±0, ±max, zero divisors and every overflow boundary.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic {
    MDU_MUL = 1'b0,
    MDU_DIV = 1'b1
  } mdu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2,
    ST_DONE = 2'd3
  } mdu_state_e;
endpackage

// File: rtl/mdu_prep.sv
// Sign stripping and divide-overflow detection on the raw request operands.
module mdu_prep
  import mdu_pkg::*;
#(
  parameter int W = 18
) (
  input  mdu_op_e        op,
  input  logic [W-1:0]   ac,
  input  logic [W-1:0]   io,
  input  logic [W-1:0]   mem,
  output logic [W-1:0]   hi_init,
  output logic [W-1:0]   lo_init,
  output logic [W-1:0]   mag_v,
  output logic           res_neg,
  output logic           rem_neg,
  output logic           ovf
);
  logic          ac_neg;
  logic [W-1:0]  ac_mag;
  logic [W-1:0]  div_hi;
  logic [W-1:0]  div_lo;

  always_comb begin
    ac_neg  = ac[W-1];
    ac_mag  = ac_neg ? ~ac : ac;
    mag_v   = mem[W-1] ? ~mem : mem;
    res_neg = ac[W-1] ^ mem[W-1];
    rem_neg = ac_neg;
    div_hi  = ac_neg ? ~ac : ac;
    div_lo  = ac_neg ? ~io : io;
    if (op == MDU_DIV) begin
      hi_init = div_hi;
      lo_init = div_lo;
      ovf     = (div_hi >= mag_v);
    end else begin
      hi_init = '0;
      lo_init = ac_mag;
      ovf     = 1'b0;
    end
  end
endmodule

// File: rtl/mdu_datapath.sv
// Magnitude loop: shift-add multiply, non-restoring divide, one step per clock.
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int W = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step_en,
  input  logic          last_step,
  input  mdu_op_e       op,
  input  logic [W-1:0]  hi_init,
  input  logic [W-1:0]  lo_init,
  input  logic [W-1:0]  mag_v,
  output logic [W-1:0]  acc,
  output logic [W-1:0]  qio,
  output logic [W-1:0]  vreg,
  output logic          tbit
);
  logic [W-1:0] mul_sum;
  logic [W-1:0] div_sum;
  logic         div_neg;

  always_comb begin
    mul_sum = acc + (qio[0] ? vreg : '0);
    div_sum = tbit ? (acc + vreg) : (acc - vreg);
    div_neg = div_sum[W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      qio  <= '0;
      vreg <= '0;
      tbit <= 1'b0;
    end else if (load) begin
      acc  <= hi_init;
      qio  <= lo_init;
      vreg <= mag_v;
      tbit <= 1'b0;
    end else if (step_en) begin
      if (op == MDU_MUL) begin
        acc <= {1'b0, mul_sum[W-1:1]};
        qio <= {mul_sum[0], qio[W-1:1]};
      end else begin
        acc  <= last_step ? div_sum : {div_sum[W-2:0], qio[W-1]};
        qio  <= {qio[W-2:0], ~div_neg};
        tbit <= div_neg;
      end
    end
  end

  // Partial product after any multiply step fits below the sign position.
  property p_mul_acc_bound;
    @(posedge clk) disable iff (!rst_n)
      (step_en && !load && op == MDU_MUL) |=> !acc[W-1];
  endproperty
  AST_MUL_ACC_BOUND: assert property (p_mul_acc_bound); // R2

  // The divisor register is frozen while the loop runs.
  property p_divisor_frozen;
    @(posedge clk) disable iff (!rst_n)
      (step_en && !load) |=> $stable(vreg);
  endproperty
  AST_DIVISOR_FROZEN: assert property (p_divisor_frozen); // R4
endmodule

// File: rtl/mdu_finish.sv
// Remainder correction and ones-complement sign application.
module mdu_finish
  import mdu_pkg::*;
#(
  parameter int W = 18
) (
  input  mdu_op_e       op,
  input  logic [W-1:0]  acc,
  input  logic [W-1:0]  qio,
  input  logic [W-1:0]  vreg,
  input  logic          tbit,
  input  logic          res_neg,
  input  logic          rem_neg,
  output logic [W-1:0]  res_ac,
  output logic [W-1:0]  res_io,
  output logic          res_skip
);
  logic [W-1:0] rem_fix;
  logic         prod_flip;
  logic         quo_flip;
  logic         rem_flip;

  always_comb begin
    rem_fix   = tbit ? (acc + vreg) : acc;
    prod_flip = res_neg && (|{acc, qio});
    quo_flip  = res_neg && (|qio);
    rem_flip  = rem_neg && (|rem_fix);
    if (op == MDU_MUL) begin
      res_ac   = prod_flip ? ~acc : acc;
      res_io   = prod_flip ? ~qio : qio;
      res_skip = 1'b0;
    end else begin
      res_ac   = quo_flip ? ~qio : qio;
      res_io   = rem_flip ? ~rem_fix : rem_fix;
      res_skip = 1'b1;
    end
  end
endmodule

// File: rtl/mdu_ctrl.sv
// Handshake and iteration sequencing.
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int W = 18
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  input  logic     out_ready,
  input  mdu_op_e  op_in,
  input  logic     ovf,
  output logic     in_ready,
  output logic     accept,
  output logic     load,
  output logic     step_en,
  output logic     last_step,
  output logic     fin,
  output logic     out_valid,
  output mdu_op_e  op_q
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] MUL_LAST = CW'(W - 2);
  localparam logic [CW-1:0] DIV_LAST = CW'(W - 1);

  mdu_state_e     state;
  logic [CW-1:0]  cnt;

  always_comb begin
    in_ready  = (state == ST_IDLE);
    accept    = in_ready && in_valid;
    load      = accept && !ovf;
    step_en   = (state == ST_RUN);
    last_step = step_en && (cnt == ((op_q == MDU_DIV) ? DIV_LAST : MUL_LAST));
    fin       = (state == ST_FIN);
    out_valid = (state == ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      op_q  <= MDU_MUL;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          op_q  <= op_in;
          cnt   <= '0;
          state <= ovf ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (last_step) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_DONE;
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  property p_ready_only_idle;
    @(posedge clk) disable iff (!rst_n)
      (out_valid || step_en || fin) |-> !in_ready;
  endproperty
  AST_READY_ONLY_IDLE: assert property (p_ready_only_idle); // R1

  property p_result_waits;
    @(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> out_valid;
  endproperty
  AST_RESULT_WAITS: assert property (p_result_waits); // R8

  property p_release;
    @(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=> (!out_valid && in_ready);
  endproperty
  AST_RELEASE: assert property (p_release); // R8

  property p_step_bound;
    @(posedge clk) disable iff (!rst_n)
      step_en |-> (cnt <= DIV_LAST);
  endproperty
  AST_STEP_BOUND: assert property (p_step_bound); // R7
endmodule

// File: rtl/ones_mdu.sv
module ones_mdu
  import mdu_pkg::*;
#(
  parameter int W = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_op,
  input  logic [W-1:0]  in_ac,
  input  logic [W-1:0]  in_io,
  input  logic [W-1:0]  in_mem,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_ac,
  output logic [W-1:0]  out_io,
  output logic          out_skip
);
  localparam int LW = $clog2(W + 3) + 1;

  mdu_op_e       op_in;
  mdu_op_e       op_q;
  logic [W-1:0]  hi_init, lo_init, mag_v;
  logic          res_neg, rem_neg, ovf;
  logic          accept, load, step_en, last_step, fin;
  logic [W-1:0]  acc, qio, vreg;
  logic          tbit;
  logic          res_neg_q, rem_neg_q;
  logic [W-1:0]  fin_ac, fin_io;
  logic          fin_skip;

  assign op_in = mdu_op_e'(in_op);

  mdu_prep #(.W(W)) u_prep (
    .op(op_in), .ac(in_ac), .io(in_io), .mem(in_mem),
    .hi_init(hi_init), .lo_init(lo_init), .mag_v(mag_v),
    .res_neg(res_neg), .rem_neg(rem_neg), .ovf(ovf)
  );

  mdu_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .op_in(op_in), .ovf(ovf), .in_ready(in_ready), .accept(accept),
    .load(load), .step_en(step_en), .last_step(last_step), .fin(fin),
    .out_valid(out_valid), .op_q(op_q)
  );

  mdu_datapath #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .load(load), .step_en(step_en),
    .last_step(last_step), .op(op_q), .hi_init(hi_init), .lo_init(lo_init),
    .mag_v(mag_v), .acc(acc), .qio(qio), .vreg(vreg), .tbit(tbit)
  );

  mdu_finish #(.W(W)) u_fin (
    .op(op_q), .acc(acc), .qio(qio), .vreg(vreg), .tbit(tbit),
    .res_neg(res_neg_q), .rem_neg(rem_neg_q),
    .res_ac(fin_ac), .res_io(fin_io), .res_skip(fin_skip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_neg_q <= 1'b0;
      rem_neg_q <= 1'b0;
      out_ac    <= '0;
      out_io    <= '0;
      out_skip  <= 1'b0;
    end else begin
      if (load) begin
        res_neg_q <= res_neg;
        rem_neg_q <= rem_neg;
      end
      if (accept && ovf) begin
        out_ac   <= in_ac;
        out_io   <= in_io;
        out_skip <= 1'b0;
      end else if (fin) begin
        out_ac   <= fin_ac;
        out_io   <= fin_io;
        out_skip <= fin_skip;
      end
    end
  end

  // Latency tracking for the checks below.
  logic [LW-1:0] lat_cnt;
  logic [LW-1:0] lat_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt <= '0;
      lat_exp <= '0;
    end else if (accept) begin
      lat_cnt <= LW'(1);
      lat_exp <= ovf ? LW'(1) : ((op_in == MDU_DIV) ? LW'(W + 2) : LW'(W + 1));
    end else if (!in_ready && !out_valid) begin
      lat_cnt <= lat_cnt + 1'b1;
    end
  end

  property p_latency;
    @(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (lat_cnt == lat_exp);
  endproperty
  AST_LATENCY: assert property (p_latency); // R7

  property p_hold;
    @(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
        ($stable(out_ac) && $stable(out_io) && $stable(out_skip));
  endproperty
  AST_HOLD: assert property (p_hold); // R8

  property p_ovf_pass;
    @(posedge clk) disable iff (!rst_n)
      (accept && ovf) |=>
        (out_valid && out_ac == $past(in_ac) && out_io == $past(in_io) && !out_skip);
  endproperty
  AST_OVF_PASS: assert property (p_ovf_pass); // R6

  property p_mul_noskip;
    @(posedge clk) disable iff (!rst_n)
      (out_valid && op_q == MDU_MUL) |-> !out_skip;
  endproperty
  AST_MUL_NOSKIP: assert property (p_mul_noskip); // R3

  property p_no_neg_zero;
    @(posedge clk) disable iff (!rst_n)
      (out_valid && op_q == MDU_MUL) |-> !(&{out_ac, out_io});
  endproperty
  AST_NO_NEG_ZERO: assert property (p_no_neg_zero); // R3
endmodule

// File: tb/sim_ones_mdu.sv
module sim_ones_mdu;
  localparam int BW = 6;
  localparam int CLK_PERIOD = 10;
  localparam int MASK = (1 << BW) - 1;

  logic clk, rst_n, in_valid, in_ready, in_op, out_valid, out_ready, out_skip;
  logic [BW-1:0] in_ac, in_io, in_mem, out_ac, out_io;
  int checks = 0;
  int errors = 0;

  ones_mdu #(.W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_ac(in_ac), .in_io(in_io), .in_mem(in_mem),
    .out_valid(out_valid), .out_ready(out_ready), .out_ac(out_ac),
    .out_io(out_io), .out_skip(out_skip)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int mag(input int x);
    return ((x >> (BW - 1)) & 1) ? (~x & MASK) : (x & MASK);
  endfunction

  function automatic int sgn(input int x);
    return (x >> (BW - 1)) & 1;
  endfunction

  task automatic do_op(input int op, input int a, input int io, input int m,
                       input bit hold, input bit noise);
    int ea, eio, esk, elat, k, sa, sio, ssk;
    string tag_ac, tag_io, tag_sk;
    if (op == 0) begin
      int p;
      p = mag(a) * mag(m) * 2;
      ea = (p >> BW) & MASK;
      eio = p & MASK;
      tag_ac = "R2"; tag_io = "R2"; tag_sk = "R3";
      if ((sgn(a) ^ sgn(m)) == 1) begin
        tag_ac = "R3"; tag_io = "R3";
        if (p != 0) begin ea = ~ea & MASK; eio = ~eio & MASK; end
      end
      esk = 0;
      elat = BW + 1;
    end else begin
      int hi, lo, v, n, q, r;
      hi = sgn(a) ? (~a & MASK) : a;
      lo = sgn(a) ? (~io & MASK) : io;
      v = mag(m);
      if (hi >= v) begin
        ea = a; eio = io; esk = 0; elat = 1;
        tag_ac = "R6"; tag_io = "R6"; tag_sk = "R6";
      end else begin
        n = ((hi << BW) | lo) >> 1;
        q = n / v;
        r = n % v;
        tag_ac = "R4"; tag_io = "R4"; tag_sk = "R6";
        if ((sgn(a) ^ sgn(m)) == 1) begin
          tag_ac = "R5";
          if (q != 0) q = ~q & MASK;
        end
        if (sgn(a) == 1) begin
          tag_io = "R5";
          if (r != 0) r = ~r & MASK;
        end
        ea = q; eio = r; esk = 1; elat = BW + 2;
      end
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_op = op[0];
    in_ac = a[BW-1:0];
    in_io = io[BW-1:0];
    in_mem = m[BW-1:0];
    @(negedge clk);
    k = 1;
    chk("R1 in_ready while busy", int'(in_ready), 0);
    if (noise) begin
      in_ac = ~in_ac;
      in_io = ~in_io;
      in_mem = in_mem ^ 1;
      in_op = ~in_op;
    end else begin
      in_valid = 1'b0;
    end
    while (!out_valid && k < 40) begin
      @(negedge clk);
      k++;
    end
    chk("R7 latency", k, elat);
    if (hold) begin
      sa = int'(out_ac); sio = int'(out_io); ssk = int'(out_skip);
      repeat (2) @(negedge clk);
      chk("R8 valid held", int'(out_valid), 1);
      chk("R8 out_ac held", int'(out_ac), sa);
      chk("R8 out_io held", int'(out_io), sio);
      chk("R8 out_skip held", int'(out_skip), ssk);
    end
    chk({tag_ac, " out_ac"}, int'(out_ac), ea);
    chk({tag_io, " out_io"}, int'(out_io), eio);
    chk({tag_sk, " out_skip"}, int'(out_skip), esk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R8 valid drops", int'(out_valid), 0);
    chk("R1 ready after release", int'(in_ready), 1);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_op = 1'b0;
    in_ac = '0;
    in_io = '0;
    in_mem = '0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset in_ready", int'(in_ready), 1);
    chk("R9 reset out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle in_ready", int'(in_ready), 1);
    chk("R9 idle out_valid", int'(out_valid), 0);

    // Multiply sweep, every operand pair, IO varied to show it is unused
    for (int a = 0; a <= MASK; a++) begin
      for (int m = 0; m <= MASK; m++) begin
        do_op(0, a, (a * 7 + m * 13) & MASK, m, ((a + m) % 7) == 0, ((a ^ m) & 1) == 1);
      end
    end
    // Divide sweep, every high-half/divisor pair, low half derived
    for (int a = 0; a <= MASK; a++) begin
      for (int m = 0; m <= MASK; m++) begin
        do_op(1, a, (a * 11 + m * 5 + 3) & MASK, m, ((a + m) % 5) == 0, ((a + m) & 2) == 2);
      end
    end
    // Extremes of the low half
    do_op(1, 0, MASK, 5, 1'b0, 1'b0);
    do_op(1, MASK, 0, 5, 1'b0, 1'b0);
    do_op(1, MASK, MASK, MASK, 1'b0, 1'b0);
    do_op(1, 1, MASK, MASK >> 1, 1'b1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule